// File: doc/BRIEF.md
# Sub-Register Aliasing Register File

This block is the integer register file of a processor core in which narrow register views share storage with wider physical registers. Eight 32-bit general registers sit in one bank: the first four are data registers with separate low-byte and high-byte views, and the other four are pointer/index registers with word and extended views only. A second bank holds six 16-bit segment registers that are never widened.

Each access names a register with a 4-bit specifier and a width with a 2-bit size code. Bit 3 of the specifier picks the bank (0 general, 1 segment) and bits 2:0 pick the register. Size codes are 0 byte, 1 word (16 bits), 2 extended (32 bits) and 3 reserved. A byte specifier 0..3 names bits 7:0 of general register 0..3, and 4..7 names bits 15:8 of general register 0..3. Writes touch only the addressed bits. Both read ports are combinational and zero-extend the selected view to 32 bits. A write lands on the clock edge, so a read in the same cycle sees the old contents.

Top module: `sub_reg_file`

## Requirements
- R1: After the active-low asynchronous reset, every register in both banks reads as zero.
- R2: An extended write (size 2) to a general register replaces all 32 bits, and an extended read of that register in the next cycle returns the written word.
- R3: A word write (size 1) to a general register replaces bits 15:0 and leaves bits 31:16 unchanged.
- R4: A byte write (size 0) with specifier 0..3 replaces bits 7:0 of general register 0..3, and with specifier 4..7 replaces bits 15:8 of general register 0..3. All other bits of that register are left unchanged.
- R5: Byte reads return the selected 8 bits in bits 7:0 of the port. Word reads return bits 15:0 in bits 15:0 of the port. All higher port bits are zero.
- R6: General registers 4..7 have no byte view: a byte write with specifier 4..7 leaves registers 4..7 unchanged.
- R7: A word or extended write to segment register 0..5 stores bits 15:0 of the write data. A word or extended read of it returns those 16 bits zero-extended.
- R8: Segment specifiers 14 and 15 and any byte access to the segment bank are invalid: the write is ignored and the read returns zero.
- R9: Size code 3 is reserved: such a write changes no register and such a read returns zero.
- R10: A read of a register in the same cycle as a write to it returns the old value. The new value is visible from the next cycle on.
- R11: The two read ports select independently and may read any two views in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| wr_spec_i | input | 4 | Write register specifier |
| wr_size_i | input | 2 | Write size code |
| wr_data_i | input | 32 | Write data, right-aligned |
| rd0_spec_i | input | 4 | Read port 0 specifier |
| rd0_size_i | input | 2 | Read port 0 size code |
| rd0_data_o | output | 32 | Read port 0 data, zero-extended |
| rd1_spec_i | input | 4 | Read port 1 specifier |
| rd1_size_i | input | 2 | Read port 1 size code |
| rd1_data_o | output | 32 | Read port 1 data, zero-extended |

## Verification
All 64 specifier and size combinations are written in turn, each with its own data word. After every write, all 64 views are read on port 0, and port 1 reads the mirrored combination. This separates a lane-select fault (high byte versus low byte) from a merge fault (untouched bits disturbed), and from decode faults on the invalid and reserved codes. Dedicated cases cover read-during-write, byte writes on the pointer-register specifiers, and the upper port bits of narrow reads taken from a register of all ones.

// File: rtl/sub_reg_file_pkg.sv
package sub_reg_file_pkg;
  localparam int unsigned SPEC_W = 4;
  localparam int unsigned SIZE_W = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_EXT  = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;
endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode
  import sub_reg_file_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned N_GPR  = 8,
  parameter int unsigned N_SEG  = 6,
  localparam int unsigned LANES      = DATA_W / BYTE_W,
  localparam int unsigned WORD_LANES = WORD_W / BYTE_W,
  localparam int unsigned IDX_W      = SPEC_W - 1
) (
  input  logic                              wr_en_i,
  input  logic [SPEC_W-1:0]                 wr_spec_i,
  input  logic [SIZE_W-1:0]                 wr_size_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  output logic [N_GPR-1:0][LANES-1:0]       gpr_lane_we_o,
  output logic [DATA_W-1:0]                 gpr_wdata_o,
  output logic [N_SEG-1:0]                  seg_we_o,
  output logic [SEG_W-1:0]                  seg_wdata_o
);
  logic [IDX_W-1:0] idx;
  logic             is_seg;
  size_e            size;

  assign idx    = wr_spec_i[IDX_W-1:0];
  assign is_seg = wr_spec_i[SPEC_W-1];
  assign size   = size_e'(wr_size_i);

  // lane-replicated data: each lane enable picks its own copy
  always_comb begin
    case (size)
      SZ_BYTE: gpr_wdata_o = {LANES{wr_data_i[BYTE_W-1:0]}};
      SZ_WORD: gpr_wdata_o = {(DATA_W/WORD_W){wr_data_i[WORD_W-1:0]}};
      default: gpr_wdata_o = wr_data_i;
    endcase
  end

  assign seg_wdata_o = wr_data_i[SEG_W-1:0];

  always_comb begin
    gpr_lane_we_o = '0;
    seg_we_o      = '0;
    if (wr_en_i) begin
      if (!is_seg) begin
        case (size)
          SZ_BYTE: gpr_lane_we_o[idx[IDX_W-2:0]][idx[IDX_W-1]] = 1'b1;
          SZ_WORD: begin
            for (int l = 0; l < WORD_LANES; l++) gpr_lane_we_o[idx][l] = 1'b1;
          end
          SZ_EXT:  gpr_lane_we_o[idx] = '1;
          default: ;
        endcase
      end else if ((size == SZ_WORD || size == SZ_EXT) && (32'(idx) < N_SEG)) begin
        seg_we_o[idx] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rf_gpr_bank.sv
module rf_gpr_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N_GPR  = 8,
  localparam int unsigned LANES = DATA_W / BYTE_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_GPR-1:0][LANES-1:0]   lane_we_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [N_GPR-1:0][DATA_W-1:0]  regs_o
);
  for (genvar g = 0; g < N_GPR; g++) begin : g_reg
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              regs_o[g][l*BYTE_W +: BYTE_W] <= '0;
        else if (lane_we_i[g][l]) regs_o[g][l*BYTE_W +: BYTE_W] <= wdata_i[l*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/rf_seg_bank.sv
module rf_seg_bank #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned N_SEG = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_SEG-1:0]             we_i,
  input  logic [SEG_W-1:0]             wdata_i,
  output logic [N_SEG-1:0][SEG_W-1:0]  regs_o
);
  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     regs_o[s] <= '0;
      else if (we_i[s]) regs_o[s] <= wdata_i;
    end
  end
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux
  import sub_reg_file_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned N_GPR  = 8,
  parameter int unsigned N_SEG  = 6,
  localparam int unsigned IDX_W = SPEC_W - 1
) (
  input  logic [SPEC_W-1:0]             spec_i,
  input  logic [SIZE_W-1:0]             size_i,
  input  logic [N_GPR-1:0][DATA_W-1:0]  gpr_i,
  input  logic [N_SEG-1:0][SEG_W-1:0]   seg_i,
  output logic [DATA_W-1:0]             data_o
);
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] byte_src;
  size_e             size;

  assign idx      = spec_i[IDX_W-1:0];
  assign size     = size_e'(size_i);
  assign byte_src = gpr_i[idx[IDX_W-2:0]];

  always_comb begin
    data_o = '0;
    if (!spec_i[SPEC_W-1]) begin
      case (size)
        SZ_BYTE: data_o[BYTE_W-1:0] = idx[IDX_W-1] ? byte_src[2*BYTE_W-1:BYTE_W]
                                                   : byte_src[BYTE_W-1:0];
        SZ_WORD: data_o[WORD_W-1:0] = gpr_i[idx][WORD_W-1:0];
        SZ_EXT:  data_o = gpr_i[idx];
        default: ;
      endcase
    end else if ((size == SZ_WORD || size == SZ_EXT) && (32'(idx) < N_SEG)) begin
      data_o[SEG_W-1:0] = seg_i[idx];
    end
  end
endmodule

// File: rtl/sub_reg_file.sv
module sub_reg_file
  import sub_reg_file_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned N_GPR  = 8,
  parameter int unsigned N_SEG  = 6,
  localparam int unsigned LANES = DATA_W / BYTE_W,
  localparam int unsigned N_RD  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SPEC_W-1:0] wr_spec_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SPEC_W-1:0] rd0_spec_i,
  input  logic [SIZE_W-1:0] rd0_size_i,
  output logic [DATA_W-1:0] rd0_data_o,
  input  logic [SPEC_W-1:0] rd1_spec_i,
  input  logic [SIZE_W-1:0] rd1_size_i,
  output logic [DATA_W-1:0] rd1_data_o
);
  logic [N_GPR-1:0][LANES-1:0]  gpr_lane_we;
  logic [DATA_W-1:0]            gpr_wdata;
  logic [N_SEG-1:0]             seg_we;
  logic [SEG_W-1:0]             seg_wdata;
  logic [N_GPR-1:0][DATA_W-1:0] gpr_q;
  logic [N_SEG-1:0][SEG_W-1:0]  seg_q;

  logic [N_RD-1:0][SPEC_W-1:0]  rd_spec;
  logic [N_RD-1:0][SIZE_W-1:0]  rd_size;
  logic [N_RD-1:0][DATA_W-1:0]  rd_data;

  rf_write_decode #(
    .DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W),
    .SEG_W(SEG_W), .N_GPR(N_GPR), .N_SEG(N_SEG)
  ) u_wdec (
    .wr_en_i      (wr_en_i),
    .wr_spec_i    (wr_spec_i),
    .wr_size_i    (wr_size_i),
    .wr_data_i    (wr_data_i),
    .gpr_lane_we_o(gpr_lane_we),
    .gpr_wdata_o  (gpr_wdata),
    .seg_we_o     (seg_we),
    .seg_wdata_o  (seg_wdata)
  );

  rf_gpr_bank #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .N_GPR(N_GPR)) u_gpr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lane_we_i(gpr_lane_we),
    .wdata_i  (gpr_wdata),
    .regs_o   (gpr_q)
  );

  rf_seg_bank #(.SEG_W(SEG_W), .N_SEG(N_SEG)) u_seg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (seg_we),
    .wdata_i(seg_wdata),
    .regs_o (seg_q)
  );

  assign rd_spec    = {rd1_spec_i, rd0_spec_i};
  assign rd_size    = {rd1_size_i, rd0_size_i};
  assign rd0_data_o = rd_data[0];
  assign rd1_data_o = rd_data[1];

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    rf_read_mux #(
      .DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W),
      .SEG_W(SEG_W), .N_GPR(N_GPR), .N_SEG(N_SEG)
    ) u_rmux (
      .spec_i(rd_spec[p]),
      .size_i(rd_size[p]),
      .gpr_i (gpr_q),
      .seg_i (seg_q),
      .data_o(rd_data[p])
    );
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import sub_reg_file_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [SPEC_W-1:0] wr_spec_i,
  input logic [SIZE_W-1:0] wr_size_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [SPEC_W-1:0] rd0_spec_i,
  input logic [SIZE_W-1:0] rd0_size_i,
  input logic [DATA_W-1:0] rd0_data_o,
  input logic [SPEC_W-1:0] rd1_spec_i,
  input logic [SIZE_W-1:0] rd1_size_i,
  input logic [DATA_W-1:0] rd1_data_o
);
  a_r2_ext_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == SZ_EXT && !wr_spec_i[SPEC_W-1]) |=>
      (rd0_size_i != SZ_EXT || rd0_spec_i != $past(wr_spec_i) ||
       rd0_data_o == $past(wr_data_i)));

  a_r5_byte_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd1_size_i == SZ_BYTE) |-> (rd1_data_o[DATA_W-1:BYTE_W] == '0));

  a_r7_seg_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd0_spec_i[SPEC_W-1] |-> (rd0_data_o[DATA_W-1:SEG_W] == '0));

  a_r8_seg_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd1_spec_i[SPEC_W-1] && (rd1_size_i == SZ_BYTE || rd1_spec_i[2:1] == 2'b11))
      |-> (rd1_data_o == '0));

  a_r9_rsvd_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd0_size_i == SZ_RSVD) |-> (rd0_data_o == '0));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_i) && $stable(rd0_spec_i) && $stable(rd0_size_i))
      |-> $stable(rd0_data_o));
endmodule

bind sub_reg_file rf_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_spec_i (wr_spec_i),
  .wr_size_i (wr_size_i),
  .wr_data_i (wr_data_i),
  .rd0_spec_i(rd0_spec_i),
  .rd0_size_i(rd0_size_i),
  .rd0_data_o(rd0_data_o),
  .rd1_spec_i(rd1_spec_i),
  .rd1_size_i(rd1_size_i),
  .rd1_data_o(rd1_data_o)
);

// File: tb/sub_reg_file_tb.sv
module sub_reg_file_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_spec_i = '0;
  logic [1:0]  wr_size_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  rd0_spec_i = '0;
  logic [1:0]  rd0_size_i = '0;
  logic [31:0] rd0_data_o;
  logic [3:0]  rd1_spec_i = '0;
  logic [1:0]  rd1_size_i = '0;
  logic [31:0] rd1_data_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] gm [8];
  logic [15:0] sm [6];

  always #5 clk_i = ~clk_i;

  sub_reg_file u_dut (.*);

  function automatic logic [31:0] model_rd(logic [3:0] s, logic [1:0] z);
    logic [2:0] i = s[2:0];
    if (z == 2'd3) return 32'h0;
    if (s[3]) begin
      if (z == 2'd0 || i > 3'd5) return 32'h0;
      return {16'h0, sm[i]};
    end
    case (z)
      2'd0:    return i[2] ? {24'h0, gm[i[1:0]][15:8]} : {24'h0, gm[i[1:0]][7:0]};
      2'd1:    return {16'h0, gm[i][15:0]};
      default: return gm[i];
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] s, logic [1:0] z);
    if (z == 2'd3) return "R9";
    if (s[3]) return (z == 2'd0 || s[2:0] > 3'd5) ? "R8" : "R7";
    case (z)
      2'd0:    return "R4";
      2'd1:    return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [3:0] s, logic [1:0] z, logic [31:0] d);
    logic [2:0] i = s[2:0];
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_spec_i = s; wr_size_i = z; wr_data_i = d;
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
    if (z != 2'd3) begin
      if (!s[3]) begin
        case (z)
          2'd0: if (i[2]) gm[i[1:0]][15:8] = d[7:0]; else gm[i[1:0]][7:0] = d[7:0];
          2'd1: gm[i][15:0] = d[15:0];
          default: gm[i] = d;
        endcase
      end else if (z != 2'd0 && i <= 3'd5) begin
        sm[i] = d[15:0];
      end
    end
  endtask

  task automatic read_all(string r1tag);
    for (int s = 0; s < 16; s++) begin
      for (int z = 0; z < 4; z++) begin
        rd0_spec_i = 4'(s);      rd0_size_i = 2'(z);
        rd1_spec_i = 4'(15 - s); rd1_size_i = 2'(3 - z);
        #1;
        check(r1tag == "" ? tag_of(4'(s), 2'(z)) : r1tag,
              rd0_data_o, model_rd(4'(s), 2'(z)));
        check(r1tag == "" ? "R11" : r1tag,
              rd1_data_o, model_rd(4'(15 - s), 2'(3 - z)));
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) gm[i] = '0;
    for (int i = 0; i < 6; i++) sm[i] = '0;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(negedge clk_i);
    read_all("R1");

    // R10: same-cycle read sees old data, next cycle sees new
    do_write(4'd1, 2'd2, 32'h1111_2222);
    @(negedge clk_i);
    rd0_spec_i = 4'd1; rd0_size_i = 2'd2;
    wr_en_i = 1'b1; wr_spec_i = 4'd1; wr_size_i = 2'd2; wr_data_i = 32'hCAFE_F00D;
    #1 check("R10", rd0_data_o, 32'h1111_2222);
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
    gm[1] = 32'hCAFE_F00D;
    check("R10", rd0_data_o, 32'hCAFE_F00D);

    // R6: byte specifiers 4..7 hit high bytes of 0..3, never pointer registers
    for (int i = 4; i < 8; i++) do_write(4'(i), 2'd2, 32'h5A5A_0000 + 32'(i));
    for (int i = 4; i < 8; i++) do_write(4'(i), 2'd0, 32'h0000_00AA);
    @(negedge clk_i);
    for (int i = 4; i < 8; i++) begin
      rd0_spec_i = 4'(i); rd0_size_i = 2'd2;
      rd1_spec_i = 4'(i - 4); rd1_size_i = 2'd1;
      #1;
      check("R6", rd0_data_o, 32'h5A5A_0000 + 32'(i));
      check("R6", rd1_data_o[15:8], 32'hAA);
    end

    // R5: narrow reads of an all-ones register clear upper port bits
    do_write(4'd2, 2'd2, 32'hFFFF_FFFF);
    @(negedge clk_i);
    rd0_spec_i = 4'd2; rd0_size_i = 2'd1;
    rd1_spec_i = 4'd6; rd1_size_i = 2'd0;
    #1;
    check("R5", rd0_data_o, 32'h0000_FFFF);
    check("R5", rd1_data_o, 32'h0000_00FF);

    // full sweep: every write code, then every read view on both ports
    for (int ws = 0; ws < 16; ws++) begin
      for (int wz = 0; wz < 4; wz++) begin
        do_write(4'(ws), 2'(wz),
                 (32'h9E37_79B9 * 32'(ws * 4 + wz + 1)) ^ 32'(ws << 20));
        @(negedge clk_i);
        read_all("");
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule